// File: doc/BRIEF.md
# Weighted Priority Arbiter with Starvation Escalation

This block picks one winner per clock among several requesters that compete for a single shared memory resource. Each request comes with its own 4-bit priority level. Level 0 is the most urgent and level 8 is the least. The level travels with the request, so a requester may use a different level on every cycle. The requester with the most urgent level wins, and ties go to the lowest requester index.

A request can also be flagged as pinned to the top. A pinned request ranks above level 0.

Each requester has a wait counter that counts how many decisions in a row it has lost. A programmable limit `n` sets how long a requester may keep losing. Once a requester has lost `n-1` decisions in a row, its next request is lifted to the same top rank as a pinned request. This lets a low-level requester get through at least once in every `n` decisions. Setting the limit to zero turns escalation off, and arbitration then uses the levels alone.

Top module: `wprio_arb`

## Requirements
- R1: `grant` is registered and has at most one bit set. It shows the decision made from the inputs sampled at the preceding rising edge. Reset clears it to all zeros.
- R2: Only a requester whose `req_valid` bit was set when sampled can be granted. When no request is valid, `grant` is zero after the next edge.
- R3: Among valid requests that are neither pinned nor escalated, the lowest level number wins. The level of requester i is `req_prio[4*i+3:4*i]`. Values 9 to 15 rank the same as 8.
- R4: Among requests of equal effective rank, the lowest requester index wins.
- R5: A valid request with its `req_fixed` bit set takes rank -1, which beats every level from 0 to 8.
- R6: A requester's wait count rises by one for each decision in which it is valid but not chosen. The count returns to zero when the requester wins or when its request is not valid. The count saturates at its maximum.
- R7: When `starve_lim` = n is not zero, a valid requester whose wait count is at least n-1 is escalated to rank -1. Under steady contention against a higher-level requester with a larger index, it therefore wins one decision in every n.
- R8: When `starve_lim` is zero, no requester is ever escalated, however long it has waited.
- R9: The level is taken from the current request on every cycle. Changing a requester's level changes the very next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | N_REQ | One request-valid bit per requester |
| req_prio | input | 4*N_REQ | Per-request level; requester i in bits 4*i+3:4*i |
| req_fixed | input | N_REQ | Per-request flag that pins the request to rank -1 |
| starve_lim | input | CNT_W | Escalation limit n; 0 turns escalation off |
| grant | output | N_REQ | Registered one-hot grant |

## Verification
The hardest condition to reach from the ports is escalation. It needs one requester to be held losing for exactly n-1 decisions in a row, with no break in its request. Any gap, or any chance win, resets its count.

The bench reaches this state with directed runs. In these runs a level-0 requester with a high index is held on continuously against a level-5 or level-8 requester with a low index, for several limit values. One run drops the request partway through, to show that the count restarts.

Long random runs then mix levels, pinned flags, limits and request gaps. They are compared against a bench model that keeps its own wait counts.

// File: rtl/wpa_pkg.sv
package wpa_pkg;
  localparam int PRIO_W    = 4;
  localparam int LVL_MAX   = 8;
  localparam int RANK_W    = 4;
  localparam int RANK_TOP  = 0;
  localparam int RANK_NONE = 15;
  typedef logic [RANK_W-1:0] rank_t;
endpackage

// File: rtl/wpa_wait_ctr.sv
module wpa_wait_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pend,
  input  logic             won,
  input  logic [CNT_W-1:0] lim,
  output logic             esc
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (!pend || won)  cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  always_comb begin
    esc = 1'b0;
    if (lim != '0) esc = (cnt >= (lim - 1'b1));
  end
endmodule

// File: rtl/wpa_rank.sv
module wpa_rank
  import wpa_pkg::*;
(
  input  logic              valid,
  input  logic [PRIO_W-1:0] prio,
  input  logic              fixed,
  input  logic              esc,
  output rank_t             rank
);
  logic [PRIO_W-1:0] lvl;

  always_comb begin
    lvl = (prio > PRIO_W'(LVL_MAX)) ? PRIO_W'(LVL_MAX) : prio;
    if (!valid)            rank = rank_t'(RANK_NONE);
    else if (fixed || esc) rank = rank_t'(RANK_TOP);
    else                   rank = rank_t'(lvl) + rank_t'(1);
  end
endmodule

// File: rtl/wpa_pick.sv
module wpa_pick
  import wpa_pkg::*;
#(
  parameter int N_REQ = 4
) (
  input  rank_t            ranks [N_REQ],
  input  logic [N_REQ-1:0] valid,
  output logic [N_REQ-1:0] win
);
  rank_t best;

  always_comb begin
    best = rank_t'(RANK_NONE);
    win  = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (valid[i] && (ranks[i] < best || win == '0)) begin
        best = ranks[i];
        win  = '0;
        win[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wprio_arb.sv
module wprio_arb
  import wpa_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_REQ-1:0]        req_valid,
  input  logic [PRIO_W*N_REQ-1:0] req_prio,
  input  logic [N_REQ-1:0]        req_fixed,
  input  logic [CNT_W-1:0]        starve_lim,
  output logic [N_REQ-1:0]        grant
);
  rank_t            ranks [N_REQ];
  logic [N_REQ-1:0] esc;
  logic [N_REQ-1:0] win;

  for (genvar g = 0; g < N_REQ; g++) begin : g_req
    wpa_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .pend (req_valid[g]),
      .won  (win[g]),
      .lim  (starve_lim),
      .esc  (esc[g])
    );
    wpa_rank u_rank (
      .valid (req_valid[g]),
      .prio  (req_prio[PRIO_W*g +: PRIO_W]),
      .fixed (req_fixed[g]),
      .esc   (esc[g]),
      .rank  (ranks[g])
    );
  end

  wpa_pick #(.N_REQ(N_REQ)) u_pick (
    .ranks (ranks),
    .valid (req_valid),
    .win   (win)
  );

  always_ff @(posedge clk) begin
    if (rst) grant <= '0;
    else     grant <= win;
  end
endmodule

// File: rtl/wpa_chk.sv
module wpa_chk
  import wpa_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int CNT_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [N_REQ-1:0]        req_valid,
  input logic [PRIO_W*N_REQ-1:0] req_prio,
  input logic [N_REQ-1:0]        req_fixed,
  input logic [CNT_W-1:0]        starve_lim,
  input logic [N_REQ-1:0]        grant
);
  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R2
  grant_valid_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((grant & ~$past(req_valid)) == '0));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid == '0) |=> (grant == '0));

  // R5
  fixed_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((starve_lim == '0) && ((req_valid & req_fixed) != '0))
      |=> ((grant & $past(req_valid & req_fixed)) != '0));
endmodule

bind wprio_arb wpa_chk #(.N_REQ(N_REQ), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/wprio_arb_test.sv
module wprio_arb_test;
  localparam int N = 4;
  localparam int CW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    v   = '0;
  logic [4*N-1:0]  pr  = '0;
  logic [N-1:0]    fx  = '0;
  logic [CW-1:0]   lim = '0;
  logic [N-1:0]    grant;

  int total = 0;
  int bad   = 0;
  int mcnt [N];
  string tag = "R1";

  always #2.5 clk = ~clk;

  wprio_arb #(.N_REQ(N), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .req_valid(v), .req_prio(pr),
    .req_fixed(fx), .starve_lim(lim), .grant(grant)
  );

  function automatic logic [N-1:0] mpick();
    int best = 100;
    logic [N-1:0] w = '0;
    for (int i = 0; i < N; i++) begin
      if (v[i]) begin
        int p = pr[4*i +: 4];
        int r;
        if (p > 8) p = 8;
        if (fx[i] || (lim != 0 && mcnt[i] >= int'(lim) - 1)) r = 0;
        else r = p + 1;
        if (r < best) begin best = r; w = '0; w[i] = 1'b1; end
      end
    end
    return w;
  endfunction

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: grant=%b expected=%b", tag, act, exp);
    end
  endtask

  // inputs are already applied away from the edge; one decision per call
  task automatic step();
    logic [N-1:0] exp = mpick();
    @(posedge clk);
    #1;
    check(grant, exp);
    for (int i = 0; i < N; i++) begin
      if (!v[i] || exp[i]) mcnt[i] = 0;
      else if (mcnt[i] < 255) mcnt[i]++;
    end
  endtask

  task automatic setp(input int i, input int p);
    pr[4*i +: 4] = 4'(p);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: grant=%b expected=finish", grant);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) mcnt[i] = 0;
    v = '1; fx = '1;
    repeat (3) @(posedge clk);
    #1;
    tag = "R1 reset"; check(grant, '0);
    rst = 1'b0; v = '0; fx = '0;

    tag = "R2 idle"; step();
    // R3: distinct levels
    tag = "R3 levels";
    v = 4'b1111; setp(0,7); setp(1,3); setp(2,5); setp(3,6); step();
    setp(1,8); step();
    // R3: values above 8 rank as 8
    tag = "R3 clamp"; v = 4'b0110; setp(1,12); setp(2,8); step();
    // R4 ties
    tag = "R4 tie"; v = 4'b1100; setp(2,4); setp(3,4); step();
    // R5 pinned beats level 0
    tag = "R5 fixed"; v = 4'b1001; setp(0,0); setp(3,8); fx = 4'b1000; step();
    fx = '0;
    // R9 level changes take effect on the next decision
    tag = "R9 per-request"; v = 4'b0011; setp(0,2); setp(1,6); step();
    setp(0,7); step();
    v = '0; step();

    // R7 escalation: low index level 5 vs high index level 0
    for (int n = 1; n <= 4; n++) begin
      tag = "R7 escalate";
      lim = CW'(n);
      v = 4'b1001; setp(0,5); setp(3,0);
      for (int k = 0; k < 3*n + 2; k++) step();
      v = '0; step();
    end
    // R6 count restarts after a dropped request
    tag = "R6 drop"; lim = 4;
    v = 4'b1001; setp(0,8); setp(3,0);
    step(); step();
    v = 4'b1000; step();
    v = 4'b1001; step(); step(); step(); step();
    // R8 no escalation with limit 0
    tag = "R8 disabled"; lim = 0;
    for (int k = 0; k < 40; k++) step();
    v = '0; step();

    // random mix
    tag = "R6 R7 random";
    for (int k = 0; k < 4000; k++) begin
      if (k % 250 == 0) lim = CW'($urandom_range(0, 5));
      v  = N'($urandom);
      fx = (($urandom_range(0, 7)) == 0) ? N'($urandom) : '0;
      for (int i = 0; i < N; i++) setp(i, $urandom_range(0, 15));
      step();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule